// File: doc/BRIEF.md
# Twenty-Second Button Stopwatch

This block is a seconds stopwatch that counts up from 00 to 20 and then stops. A prescaler divides the system clock down to a one-second tick. Each second the count, held as separate tens and units BCD digits, advances by one. A segment decoder downstream turns the two digits into display patterns.

There are two buttons. Both pass through a clock synchronizer. The start/stop button reacts only to its rising edge, so each press toggles between running and paused. A paused count resumes from the value it was holding. The clear button puts the count back to 00 at any moment.

When the count reaches 20, a done flag rises so that an LED pattern generator can begin. The count then stays at 20 until the clear button is used.

Top module: `stopwatch20`

## Requirements
- R1: While rst_ni is low and after it is released, the outputs read tens_o=0, units_o=0, running_o=0 and done_o=0.
- R2: While running, the count rises by exactly one every TICK_DIV clocks. units_o and tens_o are BCD digits. units_o goes from 9 to 0 and tens_o increments in the same step.
- R3: Each rising edge of start_btn_i toggles running_o. A button held high for many cycles toggles running_o only once. While paused, the count holds, and a later press resumes counting from the held value.
- R4: A high level on clear_btn_i sets the count to 00 and clears running_o and done_o. This applies whether the stopwatch is running, paused or finished.
- R5: The step that takes the count to 20 raises done_o and lowers running_o on the same clock edge.
- R6: When the count is 20, further ticks and start/stop presses have no effect. The outputs stay tens_o=2, units_o=0, running_o=0 and done_o=1 until a clear.
- R7: The prescaler restarts whenever counting starts or resumes. The first increment after running_o rises comes exactly TICK_DIV clocks later.
- R8: A button first sampled high at clock edge k takes effect at edge k+2. This is the latency of the two-stage synchronizer plus the state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| start_btn_i | input | 1 | Start/stop button, raw level |
| clear_btn_i | input | 1 | Clear button, raw level, active high |
| tens_o | output | 4 | Tens BCD digit of the count |
| units_o | output | 4 | Units BCD digit of the count |
| running_o | output | 1 | Stopwatch is counting |
| done_o | output | 1 | Count has reached twenty |

## Verification
The assertions check several properties on every clock cycle. The count never goes above twenty, and the units digit never leaves the BCD range. done_o and running_o are never high together. A paused count does not change. A clear always leads to the cleared state. The synchronized start pulse never lasts more than one cycle. No step happens in the cycle right after a resume.

Other behaviours need the bench scenarios. These are the exact tick period, the first full period after a resume, and a held button giving a single toggle. They also include the carry from units into tens, the two-edge button latency, and presses being ignored once twenty is reached.

// File: rtl/stopwatch_pkg.sv
package stopwatch_pkg;
  typedef logic [3:0] bcd_digit_t;

  typedef enum logic {
    SYNC_LEVEL = 1'b0,
    SYNC_RISE  = 1'b1
  } sync_mode_e;
endpackage

// File: rtl/btn_sync.sv
module btn_sync
  import stopwatch_pkg::*;
#(
  parameter int         STAGES = 2,
  parameter sync_mode_e MODE   = SYNC_LEVEL
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_i,
  output logic pulse_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], btn_i};
  end

  generate
    if (MODE == SYNC_RISE) begin : g_rise
      logic prev_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= sync_q[STAGES-1];
      end
      assign pulse_o = sync_q[STAGES-1] & ~prev_q;

      a_r3_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulse_o |=> !pulse_o);
    end else begin : g_level
      assign pulse_o = sync_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int TICK_DIV = 50_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign tick_o  = run_i & at_last;

  // held at zero while stopped, so each resume starts a full period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (at_last) cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  a_r7_count_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/bcd_count_limit.sv
module bcd_count_limit
  import stopwatch_pkg::*;
#(
  parameter int LIMIT_TENS  = 2,
  parameter int LIMIT_UNITS = 0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       inc_i,
  output bcd_digit_t tens_o,
  output bcd_digit_t units_o,
  output logic       at_limit_o,
  output logic       pre_limit_o
);
  localparam int PRE_TENS  = (LIMIT_UNITS == 0) ? LIMIT_TENS - 1 : LIMIT_TENS;
  localparam int PRE_UNITS = (LIMIT_UNITS == 0) ? 9 : LIMIT_UNITS - 1;
  localparam int LIMIT_VAL = LIMIT_TENS * 10 + LIMIT_UNITS;

  bcd_digit_t tens_q, units_q;

  assign at_limit_o  = (tens_q == 4'(LIMIT_TENS)) && (units_q == 4'(LIMIT_UNITS));
  assign pre_limit_o = (tens_q == 4'(PRE_TENS))   && (units_q == 4'(PRE_UNITS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tens_q  <= '0;
      units_q <= '0;
    end else if (clr_i) begin
      tens_q  <= '0;
      units_q <= '0;
    end else if (inc_i && !at_limit_o) begin
      if (units_q == 4'd9) begin
        units_q <= '0;
        tens_q  <= tens_q + 1'b1;
      end else begin
        units_q <= units_q + 1'b1;
      end
    end
  end

  assign tens_o  = tens_q;
  assign units_o = units_q;

  a_r2_units_bcd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    units_q <= 4'd9);
  a_r2_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(tens_q) * 10 + int'(units_q)) <= LIMIT_VAL);
  a_r6_limit_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_limit_o && !clr_i |=> at_limit_o);
endmodule

// File: rtl/stopwatch20.sv
module stopwatch20
  import stopwatch_pkg::*;
#(
  parameter int TICK_DIV    = 50_000_000,
  parameter int SYNC_STAGES = 2,
  parameter int LIMIT_TENS  = 2,
  parameter int LIMIT_UNITS = 0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_btn_i,
  input  logic       clear_btn_i,
  output logic [3:0] tens_o,
  output logic [3:0] units_o,
  output logic       running_o,
  output logic       done_o
);
  logic start_rise, clr_lvl, tick, at_limit, pre_limit;
  logic run_q;

  btn_sync #(.STAGES(SYNC_STAGES), .MODE(SYNC_RISE)) u_start_sync (
    .clk_i, .rst_ni, .btn_i(start_btn_i), .pulse_o(start_rise)
  );

  btn_sync #(.STAGES(SYNC_STAGES), .MODE(SYNC_LEVEL)) u_clear_sync (
    .clk_i, .rst_ni, .btn_i(clear_btn_i), .pulse_o(clr_lvl)
  );

  tick_prescaler #(.TICK_DIV(TICK_DIV)) u_prescaler (
    .clk_i, .rst_ni, .run_i(run_q), .tick_o(tick)
  );

  bcd_count_limit #(.LIMIT_TENS(LIMIT_TENS), .LIMIT_UNITS(LIMIT_UNITS)) u_count (
    .clk_i, .rst_ni, .clr_i(clr_lvl), .inc_i(tick),
    .tens_o, .units_o, .at_limit_o(at_limit), .pre_limit_o(pre_limit)
  );

  // clear wins; the final step stops the run in the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     run_q <= 1'b0;
    else if (clr_lvl)                run_q <= 1'b0;
    else if (tick && pre_limit)      run_q <= 1'b0;
    else if (start_rise && !at_limit) run_q <= ~run_q;
  end

  assign running_o = run_q;
  assign done_o    = at_limit;

  a_r5_done_not_running: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !running_o);
  a_r3_paused_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_o && !clr_lvl |=> $stable(tens_o) && $stable(units_o));
  a_r4_clear_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_lvl |=> (tens_o == 4'd0) && (units_o == 4'd0) && !running_o && !done_o);
  a_r7_no_step_on_resume: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(running_o) |=> $stable(tens_o) && $stable(units_o));
endmodule

// File: tb/stopwatch20_bench.sv
module stopwatch20_bench;
  localparam int DIV = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_btn = 1'b0;
  logic clear_btn = 1'b0;
  logic [3:0] tens, units;
  logic running, done;

  always #5 clk = ~clk;

  stopwatch20 #(.TICK_DIV(DIV)) u_stopwatch20 (
    .clk_i(clk), .rst_ni(rst_ni), .start_btn_i(start_btn), .clear_btn_i(clear_btn),
    .tens_o(tens), .units_o(units), .running_o(running), .done_o(done)
  );

  typedef struct {
    string      tag;
    logic [3:0] t;
    logic [3:0] u;
    logic       r;
    logic       d;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   finished = 1'b0;

  // monitor: pops expectations and compares away from the active edge
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (tens !== e.t || units !== e.u || running !== e.r || done !== e.d) begin
        errors++;
        $display("FAIL %s: got t=%0d u=%0d run=%0b done=%0b, expected t=%0d u=%0d run=%0b done=%0b",
                 e.tag, tens, units, running, done, e.t, e.u, e.r, e.d);
      end
    end
  end

  task automatic expect_out(input string tag, input int t, input int u, input bit r, input bit d);
    exp_t e;
    e.tag = tag; e.t = 4'(t); e.u = 4'(u); e.r = r; e.d = d;
    exp_q.push_back(e);
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic press_start();
    start_btn = 1'b1;
    step(3);
    start_btn = 1'b0;
  endtask

  initial begin
    #(100 * 20000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    expect_out("R1 in reset", 0, 0, 0, 0);
    rst_ni = 1'b1;
    step(2);
    expect_out("R1 after reset", 0, 0, 0, 0);

    // R8: start sampled at next edge, effective two edges later
    start_btn = 1'b1;
    step(2);
    expect_out("R8 start latency not yet", 0, 0, 0, 0);
    step(1);
    start_btn = 1'b0;
    expect_out("R3 start toggles run", 0, 0, 1, 0);

    step(DIV - 1);
    expect_out("R7 no step before full period", 0, 0, 1, 0);
    step(1);
    expect_out("R2 first step", 0, 1, 1, 0);
    step(DIV * 5);
    expect_out("R2 steady steps", 0, 6, 1, 0);

    press_start();
    expect_out("R3 pause", 0, 6, 0, 0);
    step(30);
    expect_out("R3 paused holds", 0, 6, 0, 0);

    // held press: toggle once, resume from held value with full period
    start_btn = 1'b1;
    step(3);
    expect_out("R3 resume", 0, 6, 1, 0);
    step(DIV - 1);
    expect_out("R7 full period after resume", 0, 6, 1, 0);
    step(1);
    expect_out("R7 first step after resume", 0, 7, 1, 0);
    step(DIV);
    expect_out("R3 held button toggles once", 0, 8, 1, 0);
    start_btn = 1'b0;

    step(DIV);
    expect_out("R2 units nine", 0, 9, 1, 0);
    step(DIV);
    expect_out("R2 carry into tens", 1, 0, 1, 0);
    step(DIV * 9);
    expect_out("R2 nineteen", 1, 9, 1, 0);
    step(DIV);
    expect_out("R5 reach twenty", 2, 0, 0, 1);

    step(DIV * 5);
    expect_out("R6 ticks ignored at twenty", 2, 0, 0, 1);
    press_start();
    step(DIV * 2);
    expect_out("R6 press ignored at twenty", 2, 0, 0, 1);

    clear_btn = 1'b1;
    step(2);
    expect_out("R8 clear latency not yet", 2, 0, 0, 1);
    step(1);
    expect_out("R4 clear from done", 0, 0, 0, 0);
    clear_btn = 1'b0;
    step(3);

    press_start();
    step(DIV * 3);
    expect_out("R2 count after restart", 0, 3, 1, 0);
    clear_btn = 1'b1;
    step(3);
    expect_out("R4 clear while running", 0, 0, 0, 0);
    clear_btn = 1'b0;
    step(DIV * 2);
    expect_out("R4 stays cleared", 0, 0, 0, 0);

    press_start();
    step(DIV);
    expect_out("R7 step after fresh start", 0, 1, 1, 0);

    @(negedge clk);
    #1;
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule